// File: doc/BRIEF.md
# Two-Stage Selectable Clock-Enable Divider

This block is one channel of a clock generator. It runs entirely in a single fast system clock domain. Four reference sources arrive as one-cycle enable pulses on `src_en`. A 16-bit control word picks one of them and divides its pulse rate by two programmable 4-bit stages in series. The first stage divides by its field plus one. The second stage divides the first stage's output by its field plus one. A mask bit silences the channel.

The result is a one-cycle enable pulse, `clk_en_out`. Downstream logic uses it to gate its own registers, so no clock is actually switched. Software writes the control word through `wr_en`/`wr_data` and reads it back on `rd_data`.

Compile-time flags decide whether the channel has a second divider and the two auxiliary bits. On a channel without a feature, that feature's bits always read as zero. A change to the source or divisors while the channel runs waits until both divider counters wrap, so the output never emits a shortened period.

Top module: `clkdiv_chan`

## Requirements
- R1: After reset, `rd_data` reads 0x8000 (channel disabled, source 0, both divisors 0) and `clk_en_out` is low.
- R2: A write stores `wr_data` masked by the instance's capabilities, and the value reads back on `rd_data` from the next cycle. Bits 10:8 always read 0. With all features present, writing 0xFFFF reads back 0xF8FF. With no second divider and no auxiliary bits (bit 14, bit 11, bits 7:4 absent), it reads back 0xB00F.
- R3: While bit 15 of the stored word is 1, `clk_en_out` is 0 in the following cycle and thereafter, whatever the sources do.
- R4: Bits 13:12 select the source: value k uses `src_en[k]` (0 oscillator, 1 to 3 the three PLL enables). Pulses on the other source lines have no effect on the output.
- R5: Once enabled, the channel emits one output pulse per (DIV1+1)*(DIV2+1) selected source pulses, where DIV1 is bits 3:0 and DIV2 is bits 7:4. The first output pulse comes at that count of pulses after enabling.
- R6: Each output pulse is high for exactly one cycle, in the cycle right after the selected source pulse that completes the count.
- R7: With both divisor fields at 0, every selected source pulse produces an output pulse.
- R8: A write that changes the source or divisors while enabled takes effect only after the period in progress completes under the old settings.
- R9: On an instance without the second divider, bits 7:4 read as 0 and the division is by DIV1+1 only, whatever was written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 4 | One-cycle enable pulses of the four reference sources |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Stored control word after capability masking |
| clk_en_out | output | 1 | Divided output enable pulse |

## Verification
A write shows on `rd_data` one cycle later. When the channel was disabled, the new settings are loaded one cycle after that, and the divider starts counting from there. An output pulse comes one register stage after the source pulse that completes a period. The bench drives inputs on falling edges and samples outputs on falling edges. After each enable it waits two full cycles before the first source pulse. It counts output pulses over every falling edge of a burst plus three idle cycles, so each due pulse is seen. The timing test checks the exact falling edge after a single pulse, and the reconfiguration test counts the outputs between bursts split around the write.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int DIV_W      = 4;
  localparam int SEL_W      = 2;
  localparam int NUM_SRC    = 1 << SEL_W;
  localparam int NUM_STAGES = 2;
  localparam int RSV_W      = 3;
  localparam int CTRL_W     = 16;

  // Control word layout, most significant field first.
  typedef struct packed {
    logic             dis;
    logic             aux14;
    logic [SEL_W-1:0] sel;
    logic             aux11;
    logic [RSV_W-1:0] rsv;
    logic [DIV_W-1:0] div2;
    logic [DIV_W-1:0] div1;
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h8000;

  // Bits that an instance with the given features keeps on a write.
  function automatic logic [CTRL_W-1:0] write_mask(bit has_div2, bit has_aux14, bit has_aux11);
    ctrl_t m;
    m       = '0;
    m.dis   = 1'b1;
    m.sel   = '1;
    m.div1  = '1;
    m.div2  = has_div2 ? '1 : '0;
    m.aux14 = has_aux14;
    m.aux11 = has_aux11;
    return m;
  endfunction

  // Source pulses per output pulse.
  function automatic int unsigned div_ratio(logic [DIV_W-1:0] d1, logic [DIV_W-1:0] d2);
    return (int'(d1) + 1) * (int'(d2) + 1);
  endfunction
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
`timescale 1ns/1ps
module clkdiv_ctrl_reg import clkdiv_pkg::*; #(
  parameter bit HAS_DIV2  = 1'b1,
  parameter bit HAS_AUX14 = 1'b1,
  parameter bit HAS_AUX11 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output ctrl_t             ctrl_q
);
  localparam logic [CTRL_W-1:0] KEEP = write_mask(HAS_DIV2, HAS_AUX14, HAS_AUX11);

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= ctrl_t'(CTRL_RESET & KEEP);
    else if (wr_en) ctrl_q <= ctrl_t'(wr_data & KEEP);
  end
endmodule

// File: rtl/clkdiv_stage.sv
`timescale 1ns/1ps
module clkdiv_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         wrap,
  output logic [W-1:0] cnt
);
  assign wrap = step && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (step)     cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/clkdiv_chan.sv
`timescale 1ns/1ps
module clkdiv_chan import clkdiv_pkg::*; #(
  parameter bit HAS_DIV2  = 1'b1,
  parameter bit HAS_AUX14 = 1'b1,
  parameter bit HAS_AUX11 = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  output logic [CTRL_W-1:0]  rd_data,
  output logic               clk_en_out
);
  ctrl_t reg_cfg;

  // Settings in use by the divider; refreshed only at safe points.
  logic             act_dis;
  logic [SEL_W-1:0] act_sel;
  logic [DIV_W-1:0] act_div1, act_div2;

  logic                              clr, sel_pulse, frame_end, cfg_load;
  logic [NUM_STAGES-1:0]             step, wrap;
  logic [NUM_STAGES-1:0][DIV_W-1:0]  limit, stage_cnt;

  clkdiv_ctrl_reg #(
    .HAS_DIV2(HAS_DIV2), .HAS_AUX14(HAS_AUX14), .HAS_AUX11(HAS_AUX11)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(reg_cfg)
  );

  assign rd_data   = reg_cfg;
  assign clr       = reg_cfg.dis | act_dis;
  assign sel_pulse = src_en[act_sel];
  assign limit[0]  = act_div1;
  assign limit[1]  = act_div2;

  generate
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign step[g] = sel_pulse & ~clr;
      end else begin : g_next
        assign step[g] = wrap[g-1];
      end
      clkdiv_stage #(.W(DIV_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(step[g]),
        .limit(limit[g]), .wrap(wrap[g]), .cnt(stage_cnt[g])
      );
    end
  endgenerate

  assign frame_end = wrap[NUM_STAGES-1];
  assign cfg_load  = clr | frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_dis  <= 1'b1;
      act_sel  <= '0;
      act_div1 <= '0;
      act_div2 <= '0;
    end else if (cfg_load) begin
      act_dis  <= reg_cfg.dis;
      act_sel  <= reg_cfg.sel;
      act_div1 <= reg_cfg.div1;
      act_div2 <= reg_cfg.div2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) clk_en_out <= 1'b0;
    else        clk_en_out <= frame_end;
  end
endmodule

// File: rtl/clkdiv_chan_chk.sv
`timescale 1ns/1ps
module clkdiv_chan_chk import clkdiv_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] rd_data,
  input logic              clk_en_out,
  input logic              sel_pulse,
  input logic              frame_end,
  input logic              act_dis,
  input logic [SEL_W-1:0]  act_sel,
  input logic [DIV_W-1:0]  act_div1,
  input logic [DIV_W-1:0]  act_div2,
  input logic [DIV_W-1:0]  cnt1
);
  logic [SEL_W+2*DIV_W-1:0] act_vec;
  assign act_vec = {act_sel, act_div2, act_div1};

  // R3
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15] |=> !clk_en_out);

  // R6
  out_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> $past(sel_pulse));

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[10:8] == 3'b000);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vec != $past(act_vec)) |-> $past(frame_end || rd_data[15] || act_dis));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_dis |-> (cnt1 <= act_div1));
endmodule

bind clkdiv_chan clkdiv_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .clk_en_out(clk_en_out),
  .sel_pulse(sel_pulse), .frame_end(frame_end), .act_dis(act_dis),
  .act_sel(act_sel), .act_div1(act_div1), .act_div2(act_div2),
  .cnt1(stage_cnt[0])
);

// File: tb/test_clkdiv_chan.sv
`timescale 1ns/1ps
module test_clkdiv_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  src_en;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_f, rd_l;
  logic        out_f, out_l;

  int nchk = 0, nfail = 0, cnt_f = 0, cnt_l = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkdiv_chan i_clkdiv_chan (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_f), .clk_en_out(out_f)
  );

  clkdiv_chan #(.HAS_DIV2(1'b0), .HAS_AUX14(1'b0), .HAS_AUX11(1'b0)) i_clkdiv_chan_lite (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_l), .clk_en_out(out_l)
  );

  localparam int NV = 5;
  localparam logic [15:0] VEC_CFG [NV] = '{16'h0000, 16'h1002, 16'h2031, 16'h30FF, 16'h0012};
  localparam int          VEC_N   [NV] = '{10, 12, 17, 260, 13};

  function automatic int expect_pulses(logic [15:0] cfg, int n, bit has_div2);
    int r;
    r = (cfg[3:0] + 1) * ((has_div2 ? int'(cfg[7:4]) : 0) + 1);
    return n / r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Disable, then enable with v, then let the settings load.
  task automatic start_cfg(input logic [15:0] v);
    write_cfg(v | 16'h8000);
    write_cfg(v);
    @(negedge clk);
  endtask

  task automatic tally();
    cnt_f += int'(out_f);
    cnt_l += int'(out_l);
  endtask

  task automatic run(input logic [3:0] pm, input logic [3:0] nm, input int n);
    cnt_f = 0; cnt_l = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tally(); src_en = pm | nm;
      @(negedge clk); tally(); src_en = nm;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tally();
    end
    src_en = 4'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_en = 4'h0; wr_en = 1'b0; wr_data = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rd_f == 16'h8000, "R1 full readback", rd_f, 16'h8000);
    check(rd_l == 16'h8000, "R1 lite readback", rd_l, 16'h8000);
    check(out_f == 1'b0, "R1 output low", out_f, 0);

    // R2 capability masking
    write_cfg(16'hFFFF);
    check(rd_f == 16'hF8FF, "R2 full mask", rd_f, 16'hF8FF);
    check(rd_l == 16'hB00F, "R2 lite mask", rd_l, 16'hB00F);

    // R4 R5 R7 vector table
    for (int v = 0; v < NV; v++) begin
      logic [3:0] pm;
      pm = 4'b0001 << VEC_CFG[v][13:12];
      start_cfg(VEC_CFG[v]);
      check(rd_f == VEC_CFG[v], "R2 table readback", rd_f, VEC_CFG[v]);
      run(pm, ~pm, VEC_N[v]);
      check(cnt_f == expect_pulses(VEC_CFG[v], VEC_N[v], 1'b1), "R5 table pulse count",
            cnt_f, expect_pulses(VEC_CFG[v], VEC_N[v], 1'b1));
    end

    // R6 exact timing, R7 divide-by-one
    start_cfg(16'h0000);
    @(negedge clk); src_en = 4'b0001;
    @(negedge clk); src_en = 4'b0000;
    check(out_f == 1'b1, "R6 pulse one cycle later", out_f, 1);
    @(negedge clk);
    check(out_f == 1'b0, "R6 pulse one cycle wide", out_f, 0);

    // R3 disable masks output
    write_cfg(16'h8000);
    run(4'b0001, 4'b1110, 5);
    check(cnt_f == 0, "R3 disabled output", cnt_f, 0);

    // R4 unselected sources ignored
    start_cfg(16'h1000);
    run(4'b0001, 4'b0000, 6);
    check(cnt_f == 0, "R4 unselected line", cnt_f, 0);
    run(4'b0010, 4'b0000, 4);
    check(cnt_f == 4, "R4 selected line", cnt_f, 4);

    // R8 reconfiguration waits for period end
    start_cfg(16'h0003);
    run(4'b0001, 4'b0000, 2);
    check(cnt_f == 0, "R8 first half", cnt_f, 0);
    write_cfg(16'h0001);
    run(4'b0001, 4'b0000, 2);
    check(cnt_f == 1, "R8 old period completes", cnt_f, 1);
    run(4'b0001, 4'b0000, 2);
    check(cnt_f == 1, "R8 new divisor applies", cnt_f, 1);

    // R9 lite instance ignores second divider
    start_cfg(16'h10F1);
    check(rd_l == 16'h1001, "R9 lite readback", rd_l, 16'h1001);
    run(4'b0010, 4'b1101, 10);
    check(cnt_l == expect_pulses(16'h10F1, 10, 1'b0), "R9 lite pulse count",
          cnt_l, expect_pulses(16'h10F1, 10, 1'b0));
    check(cnt_f == expect_pulses(16'h10F1, 10, 1'b1), "R9 full pulse count",
          cnt_f, expect_pulses(16'h10F1, 10, 1'b1));

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule